// File: doc/BRIEF.md
# BCD Digit Register Display Driver

This block holds four binary-coded-decimal digits written by a host and shows them on a four-digit multiplexed seven-segment display. The host places a 4-bit digit value and a 2-bit digit address on its inputs and then raises a write strobe. On the rising edge of the strobe, the value is copied into the addressed digit register. The block has no read path.

A free-running prescaler divides the system clock. Each time the prescaler wraps, a 2-bit scan counter moves on to the next digit. The digit under the scan counter is decoded into segment drives, and the matching digit-common enable is asserted. Only one digit is lit at any moment. At a fast enough scan rate, all four digits appear lit together. An active-low global clear empties all four digit registers and restarts the scan.

Top module: `bcd_scan_display`

## Requirements
- R1: While `clr_n` is low, and directly after it is released, every digit register holds 0, the scan sits on digit 0, `dig_en` is 4'b0001 and `seg` shows the pattern for 0 (7'h3F).
- R2: A digit register loads only in the clock cycle in which `wr_stb` is seen rising (low in the previous cycle, high in this one). Holding `wr_stb` high, or changing `wr_data` or `wr_addr` while it stays high, leaves all registers unchanged.
- R3: The value and address captured are those present on `wr_data` and `wr_addr` in the clock cycle in which the rise of `wr_stb` is seen. `wr_addr` value k selects digit k.
- R4: `seg` is active high, with bit 0 driving segment a through bit 6 driving segment g. Codes 0..9 give 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R5: Codes 10 through 15 turn off every segment (`seg` = 0) while their digit is scanned.
- R6: The scan digit advances by one every 2**DIV_BITS clock cycles, in the order 0, 1, 2, 3, 0.
- R7: `dig_en` is always one-hot. Bit k is set exactly when digit k is scanned, and `seg` shows that digit's decoded code.
- R8: Pulling `clr_n` low at any time clears all four digit registers and the prescaler, and returns the scan to digit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Asynchronous active-low global clear |
| wr_stb | input | 1 | Write strobe; its rising edge loads a digit |
| wr_addr | input | 2 | Digit register to write |
| wr_data | input | 4 | BCD value to write |
| seg | output | 7 | Segment drives a..g, active high |
| dig_en | output | 4 | One-hot digit-common enable |

## Verification
The bench builds the block with DIV_BITS = 2, so the scan advances every four cycles. At that rate every digit is visited many times within a short run. A small prescaler also puts the wrap and the scan step close to writes, to held strobes and to a clear issued mid-scan, so these events overlap in ways they rarely would at the default of 16. Every code from 0 to 15 is written and then shown on its digit, and both the decoded codes and the blanked codes are compared cycle by cycle against a behavioural model.

// File: rtl/bcd_scan_display.sv
module bcd_scan_display #(
  parameter int DIV_BITS = 16
) (
  input  logic       clk,
  input  logic       clr_n,
  input  logic       wr_stb,
  input  logic [1:0] wr_addr,
  input  logic [3:0] wr_data,
  output logic [6:0] seg,
  output logic [3:0] dig_en
);

  logic [DIV_BITS-1:0] div_cnt;
  logic [1:0]          scan;
  logic                stb_q;
  logic [3:0]          digits [4];
  logic [3:0]          cur;

  wire tick = &div_cnt;
  wire load = wr_stb & ~stb_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      div_cnt <= '0;
      scan    <= '0;
      stb_q   <= 1'b0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
      stb_q   <= wr_stb;
      if (tick) scan <= scan + 2'd1;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_dig
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)                        digits[k] <= 4'd0;
      else if (load && wr_addr == 2'(k)) digits[k] <= wr_data;
    end
  end

  assign cur    = digits[scan];
  assign dig_en = 4'b0001 << scan;

  always_comb begin
    case (cur)
      4'd0:    seg = 7'h3F;
      4'd1:    seg = 7'h06;
      4'd2:    seg = 7'h5B;
      4'd3:    seg = 7'h4F;
      4'd4:    seg = 7'h66;
      4'd5:    seg = 7'h6D;
      4'd6:    seg = 7'h7D;
      4'd7:    seg = 7'h07;
      4'd8:    seg = 7'h7F;
      4'd9:    seg = 7'h6F;
      default: seg = 7'h00;
    endcase
  end

  AST_DIG_ONEHOT: assert property (@(posedge clk) disable iff (!clr_n) $onehot(dig_en)); // R7
  AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (!clr_n) !tick |=> $stable(dig_en)); // R6
  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!clr_n) (tick && dig_en[3]) |=> dig_en[0]); // R6
  AST_BLANK_CODE: assert property (@(posedge clk) disable iff (!clr_n) (cur > 4'd9) |-> (seg == 7'h00)); // R5
  AST_LOAD_EDGE: assert property (@(posedge clk) disable iff (!clr_n) load |=> digits[$past(wr_addr)] == $past(wr_data)); // R3
  AST_NO_LOAD: assert property (@(posedge clk) disable iff (!clr_n) !load |=> ($stable(digits[0]) && $stable(digits[1]) && $stable(digits[2]) && $stable(digits[3]))); // R2

endmodule

// File: tb/tb_bcd_scan_display.sv
module tb_bcd_scan_display;
  localparam int CLK_PERIOD = 10;
  localparam int DIVB = 2;

  logic       clk = 0;
  logic       clr_n = 0;
  logic       wr_stb = 0;
  logic [1:0] wr_addr = 0;
  logic [3:0] wr_data = 0;
  logic [6:0] seg;
  logic [3:0] dig_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bcd_scan_display #(.DIV_BITS(DIVB)) dut (
    .clk(clk), .clr_n(clr_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .seg(seg), .dig_en(dig_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_cycles;
  int m_digit;
  int m_regs [4];
  bit m_prev;

  function automatic logic [6:0] pattern(input int code);
    case (code)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  always @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      m_cycles = 0; m_digit = 0; m_prev = 0;
      for (int i = 0; i < 4; i++) m_regs[i] = 0;
    end else begin
      if (wr_stb && !m_prev) m_regs[int'(wr_addr)] = int'(wr_data);
      m_prev = wr_stb;
      m_cycles = m_cycles + 1;
      if (m_cycles == (1 << DIVB)) begin
        m_cycles = 0;
        m_digit = (m_digit + 1) % 4;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (clr_n && !done) begin
      logic [3:0] e_en;
      logic [6:0] e_seg;
      e_en = 4'b0001 << m_digit;
      e_seg = pattern(m_regs[m_digit]);
      check(dig_en === e_en, "R6/R7 dig_en", int'(dig_en), int'(e_en));
      check(seg === e_seg, (m_regs[m_digit] > 9) ? "R5 seg" : "R4 seg", int'(seg), int'(e_seg));
    end
  end

  task automatic write(input int a, input int d);
    @(negedge clk);
    wr_addr = 2'(a); wr_data = 4'(d); wr_stb = 1;
    @(negedge clk);
    wr_stb = 0;
    @(negedge clk);
  endtask

  task automatic wait_digit(input int k);
    do @(negedge clk); while (dig_en !== (4'b0001 << k));
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dig_en === 4'b0001, "R1 reset dig_en", int'(dig_en), 1);
    check(seg === 7'h3F, "R1 reset seg", int'(seg), 'h3F);
    clr_n = 1;
    @(negedge clk);
    check(seg === 7'h3F && dig_en === 4'b0001, "R1 after release", int'(seg), 'h3F);

    // R3 digits 1..4 into addresses 0..3
    for (int i = 0; i < 4; i++) write(i, i + 1);
    for (int i = 0; i < 4; i++) begin
      wait_digit(i);
      check(seg === pattern(i + 1), "R3 addressed digit", int'(seg), int'(pattern(i + 1)));
    end
    // R4 codes 0..9 and R5 codes 10..15 on rotating addresses
    for (int c = 0; c < 16; c++) begin
      write(c % 4, c);
      wait_digit(c % 4);
      check(seg === pattern(c), (c > 9) ? "R5 blank" : "R4 decode", int'(seg), int'(pattern(c)));
    end

    // R2 held strobe: one load, later changes ignored
    @(negedge clk);
    wr_addr = 0; wr_data = 4'd8; wr_stb = 1;
    @(negedge clk);
    wr_data = 4'd2; wr_addr = 2'd1;
    repeat (5) @(negedge clk);
    wr_data = 4'd5;
    repeat (3) @(negedge clk);
    wr_stb = 0;
    wait_digit(0);
    check(seg === 7'h7F, "R2 held strobe digit0", int'(seg), 'h7F);
    wait_digit(1);
    check(seg === pattern(13), "R2 held strobe digit1", int'(seg), int'(pattern(13)));

    // R6 scan period
    wait_digit(2);
    repeat ((1 << DIVB) - 1) @(negedge clk);
    check(dig_en === 4'b0100, "R6 hold within period", int'(dig_en), 4);
    @(negedge clk);
    check(dig_en === 4'b1000, "R6 step after period", int'(dig_en), 8);

    // R8 clear mid-scan
    write(3, 9);
    wait_digit(2);
    @(negedge clk);
    clr_n = 0;
    #1;
    check(dig_en === 4'b0001, "R8 clear scan", int'(dig_en), 1);
    check(seg === 7'h3F, "R8 clear seg", int'(seg), 'h3F);
    @(negedge clk);
    clr_n = 1;
    for (int i = 0; i < 4; i++) begin
      wait_digit(i);
      check(seg === 7'h3F, "R8 cleared register", int'(seg), 'h3F);
    end

    repeat (20) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule